// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block turns a virtual address into a physical address for a processor running several programs at once. The upper bits of the virtual address name a segment and the lower bits give an offset within it. The block keeps a small table with one entry per segment; each entry holds a start address in physical memory, the last legal offset, and an in-use flag. A request checks the offset against the entry's bound and adds the start address to form the physical address. An offset past the bound, or a segment whose entry is not in use, produces a protection fault flag instead of an address.

The operating system loads table entries through a write port when it switches between programs. A build-time parameter picks a second checking variant for equal-size partitions: there the stored bound is ignored and every offset is compared with a fixed partition size. The result of each request is registered and appears one cycle later.

Top module: `seg_xlate`

## Requirements
- R1: After reset all table entries are not in use, and rsp_valid, rsp_fault and rsp_paddr are all zero.
- R2: The segment number is vaddr[15:14] and the offset is vaddr[13:0]; a request that passes its checks returns rsp_paddr equal to the entry's base plus the offset, taken modulo 2^18.
- R3: In the default bounded variant an offset greater than the entry's stored limit faults, while an offset equal to the limit is accepted.
- R4: A request to a segment whose entry is not in use faults, whatever its offset.
- R5: Whenever rsp_fault is 1, rsp_paddr is 0.
- R6: The response to a request held on req_valid at one rising clock edge appears at the outputs after that edge, with rsp_valid 1, and lasts one cycle.
- R7: In a cycle after which no request was taken, rsp_valid, rsp_fault and rsp_paddr are 0.
- R8: A write (wr_en 1) stores wr_valid, wr_base and wr_limit into entry wr_idx; requests taken from the next edge on see it, while a request taken in the same cycle as the write sees the previous contents.
- R9: A write to one entry leaves every other entry unchanged.
- R10: In the equal-partition variant (parameter FIXED_PART set, partition size PART_SIZE, 4096 in the bench) an in-use entry faults exactly when the offset is at least PART_SIZE; the stored limit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Load one table entry this cycle |
| wr_idx | input | 2 | Entry to load |
| wr_valid | input | 1 | In-use flag to store |
| wr_base | input | 18 | Physical start address to store |
| wr_limit | input | 14 | Last legal offset to store |
| req_valid | input | 1 | A translation request is present |
| req_vaddr | input | 16 | Virtual address: segment in [15:14], offset in [13:0] |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Protection fault for the request |
| rsp_paddr | output | 18 | Translated physical address, 0 on fault |

## Verification
Every request result is due exactly one clock edge after the edge that takes it, and a table write is due to affect requests taken from the following edge onward. The bench drives inputs on the falling edge, computes the expected response from its own model of the table before applying that cycle's write to the model, and compares the outputs one time unit after the next rising edge. Two instances, one per checking variant, share the stimulus and are compared on every cycle against the same model.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    // Which bound is applied to the offset of a request.
    typedef enum logic {
        CHK_STORED_LIMIT = 1'b0,
        CHK_FIXED_SIZE   = 1'b1
    } chk_mode_e;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int NUM_SEG = 4,
    parameter int PA_W    = 18,
    parameter int OFF_W   = 14,
    localparam int IDX_W  = $clog2(NUM_SEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [OFF_W-1:0] wr_limit,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [PA_W-1:0]  rd_base,
    output logic [OFF_W-1:0] rd_limit
);
    typedef struct packed {
        logic             used;
        logic [PA_W-1:0]  base;
        logic [OFF_W-1:0] limit;
    } entry_t;

    entry_t ent_d [NUM_SEG];
    entry_t ent_q [NUM_SEG];

    // Next value for every entry: only the addressed one takes the write.
    always_comb begin
        for (int i = 0; i < NUM_SEG; i++) begin
            ent_d[i] = ent_q[i];
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                ent_d[i].used  = wr_valid;
                ent_d[i].base  = wr_base;
                ent_d[i].limit = wr_limit;
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ent_q[g] <= '0;
                end else begin
                    ent_q[g] <= ent_d[g];
                end
            end
        end
    endgenerate

    // Read sees the registered contents, so a same-cycle write is not visible.
    always_comb begin
        rd_valid = ent_q[rd_idx].used;
        rd_base  = ent_q[rd_idx].base;
        rd_limit = ent_q[rd_idx].limit;
    end
endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter chk_mode_e MODE      = CHK_STORED_LIMIT,
    parameter int        PA_W      = 18,
    parameter int        OFF_W     = 14,
    parameter int        PART_SIZE = 4096
) (
    input  logic             ent_valid,
    input  logic [PA_W-1:0]  ent_base,
    input  logic [OFF_W-1:0] ent_limit,
    input  logic [OFF_W-1:0] offset,
    output logic             fault,
    output logic [PA_W-1:0]  paddr
);
    localparam logic [OFF_W:0] PART_BOUND = (OFF_W+1)'(PART_SIZE);

    logic in_range;

    generate
        if (MODE == CHK_FIXED_SIZE) begin : g_fixed
            logic unused_limit;
            assign unused_limit = ^ent_limit;
            assign in_range = ({1'b0, offset} < PART_BOUND);
        end else begin : g_bounded
            assign in_range = (offset <= ent_limit);
        end
    endgenerate

    always_comb begin
        fault = !ent_valid || !in_range;
        paddr = fault ? '0 : (ent_base + PA_W'(offset));
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int        SEG_W      = 2,
    parameter int        OFF_W      = 14,
    parameter int        PA_W       = 18,
    parameter bit        FIXED_PART = 1'b0,
    parameter int        PART_SIZE  = 4096,
    localparam int       VA_W       = SEG_W + OFF_W,
    localparam int       NUM_SEG    = 1 << SEG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [OFF_W-1:0] wr_limit,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr
);
    localparam chk_mode_e MODE = FIXED_PART ? CHK_FIXED_SIZE : CHK_STORED_LIMIT;

    typedef struct packed {
        logic            valid;
        logic            fault;
        logic [PA_W-1:0] paddr;
    } rsp_t;

    logic [SEG_W-1:0] seg_num;
    logic [OFF_W-1:0] seg_off;
    logic             ent_valid;
    logic [PA_W-1:0]  ent_base;
    logic [OFF_W-1:0] ent_limit;
    logic             chk_fault;
    logic [PA_W-1:0]  chk_paddr;
    rsp_t             rsp_d;
    rsp_t             rsp_q;

    assign seg_num = req_vaddr[VA_W-1:OFF_W];
    assign seg_off = req_vaddr[OFF_W-1:0];

    seg_table #(
        .NUM_SEG (NUM_SEG),
        .PA_W    (PA_W),
        .OFF_W   (OFF_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_valid (wr_valid),
        .wr_base  (wr_base),
        .wr_limit (wr_limit),
        .rd_idx   (seg_num),
        .rd_valid (ent_valid),
        .rd_base  (ent_base),
        .rd_limit (ent_limit)
    );

    seg_check #(
        .MODE      (MODE),
        .PA_W      (PA_W),
        .OFF_W     (OFF_W),
        .PART_SIZE (PART_SIZE)
    ) u_check (
        .ent_valid (ent_valid),
        .ent_base  (ent_base),
        .ent_limit (ent_limit),
        .offset    (seg_off),
        .fault     (chk_fault),
        .paddr     (chk_paddr)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.fault = chk_fault;
            rsp_d.paddr = chk_paddr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_fault = rsp_q.fault;
    assign rsp_paddr = rsp_q.paddr;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int PA_W = 18
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            rsp_valid,
    input logic            rsp_fault,
    input logic [PA_W-1:0] rsp_paddr
);
    // R5: a fault never carries an address
    a_r5_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0));

    // R6: a taken request is answered after the next edge
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R7: no request taken means a silent response
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_fault && rsp_paddr == '0));

    // R7: outputs only move while a response is present
    a_r7_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_fault && rsp_paddr == '0));
endmodule

bind seg_xlate seg_xlate_chk #(.PA_W(PA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr)
);

// File: tb/seg_xlate_test.sv
`timescale 1ns/1ps
module seg_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic        wr_valid = 1'b0;
    logic [17:0] wr_base = '0;
    logic [13:0] wr_limit = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_vaddr = '0;
    logic        rsp_valid, rsp_fault;
    logic [17:0] rsp_paddr;
    logic        fx_valid, fx_fault;
    logic [17:0] fx_paddr;

    int tests = 0;
    int fails = 0;

    // Behavioural model of the table
    bit mv [4];
    int mb [4];
    int ml [4];
    logic [19:0] exp_b, exp_f;

    always #2.5 clk = ~clk;

    seg_xlate uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_valid(wr_valid), .wr_base(wr_base), .wr_limit(wr_limit),
        .req_valid(req_valid), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    seg_xlate #(.FIXED_PART(1'b1), .PART_SIZE(4096)) uut_fix (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_valid(wr_valid), .wr_base(wr_base), .wr_limit(wr_limit),
        .req_valid(req_valid), .req_vaddr(req_vaddr),
        .rsp_valid(fx_valid), .rsp_fault(fx_fault), .rsp_paddr(fx_paddr)
    );

    task automatic check(input logic [19:0] act, input logic [19:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got v=%0b f=%0b pa=%05h, expected v=%0b f=%0b pa=%05h",
                     tag, act[19], act[18], act[17:0], exp[19], exp[18], exp[17:0]);
        end
    endtask

    function automatic logic [19:0] model(bit rv, int va, bit fixed);
        int seg, off;
        bit flt;
        if (!rv) return '0;
        seg = (va >> 14) & 3;
        off = va & 16'h3FFF;
        if (fixed) flt = !mv[seg] || (off >= 4096);
        else       flt = !mv[seg] || (off > ml[seg]);
        if (flt) return {2'b11, 18'h0};
        return {2'b10, 18'((mb[seg] + off) & 18'h3FFFF)};
    endfunction

    // One cycle: drive on falling edge, compare after the rising edge.
    task automatic step(input bit we, input int wi, input bit wv, input int wb,
                        input int wl, input bit rv, input int va, input string tag);
        @(negedge clk);
        wr_en = we; wr_idx = 2'(wi); wr_valid = wv; wr_base = 18'(wb);
        wr_limit = 14'(wl); req_valid = rv; req_vaddr = 16'(va);
        exp_b = model(rv, va, 1'b0);
        exp_f = model(rv, va, 1'b1);
        if (we) begin
            mv[wi & 3] = wv; mb[wi & 3] = wb & 18'h3FFFF; ml[wi & 3] = wl & 14'h3FFF;
        end
        @(posedge clk);
        #1;
        check({rsp_valid, rsp_fault, rsp_paddr}, exp_b, tag);
        check({fx_valid, fx_fault, fx_paddr}, exp_f, {tag, " R10 fixed"});
    endtask

    task automatic load(input int wi, input bit wv, input int wb, input int wl, input string tag);
        step(1'b1, wi, wv, wb, wl, 1'b0, 0, tag);
    endtask

    task automatic req(input int va, input string tag);
        step(1'b0, 0, 1'b0, 0, 0, 1'b1, va, tag);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin mv[i] = 0; mb[i] = 0; ml[i] = 0; end
        #1;
        check({rsp_valid, rsp_fault, rsp_paddr}, 20'h0, "R1 outputs in reset");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: all entries start unused
        for (int s = 0; s < 4; s++) req(s << 14, "R1 R4 entry unused after reset");

        // Program the table
        load(0, 1, 18'h01000, 14'h0FFF, "R8 load 0");
        load(1, 1, 18'h20000, 14'h3FFF, "R8 load 1");
        load(2, 1, 18'h3FFF0, 14'h0100, "R8 load 2");
        load(3, 0, 18'h05000, 14'h3FFF, "R8 load 3 unused");

        // R2: translations in each segment
        req(16'h0468, "R2 seg0 offset 0x468");
        req(16'h4000, "R2 seg1 offset 0");
        req(16'h7ABC, "R2 seg1 offset 0x3ABC");
        req(16'h8020, "R2 seg2 wrap modulo 2^18");
        // R3: bound edges
        req(16'h0FFF, "R3 offset equals limit");
        req(16'h1000, "R3 offset one past limit");
        req(16'h8100, "R3 seg2 equals limit");
        req(16'h8101, "R3 seg2 past limit");
        // R4 and R5
        req(16'hC000, "R4 R5 unused entry offset 0");
        req(16'hC123, "R4 unused entry");
        // R10: fixed partition boundary with a large stored limit
        req(16'h4FFF, "R10 offset 4095 in range");
        req(16'h5000, "R10 offset 4096 out of range");
        // R7: idle cycles
        step(1'b0, 0, 0, 0, 0, 1'b0, 16'h0468, "R7 idle with address held");
        step(1'b0, 0, 0, 0, 0, 1'b0, 16'hFFFF, "R7 idle");
        // R8: request in the write cycle sees old contents
        step(1'b1, 0, 1, 18'h10000, 14'h0010, 1'b1, 16'h0200, "R8 same-cycle write old data");
        req(16'h0200, "R8 new limit applies next cycle");
        req(16'h0008, "R8 new base applies next cycle");
        // R9: others unchanged after write to entry 0
        req(16'h4005, "R9 seg1 unchanged");
        req(16'h8005, "R9 seg2 unchanged");
        req(16'hC005, "R9 seg3 still unused");
        // Invalidate and back-to-back requests (R6)
        load(1, 0, 18'h20000, 14'h3FFF, "R8 invalidate 1");
        req(16'h4005, "R4 invalidated entry");
        load(3, 1, 18'h00000, 14'h0000, "R8 enable 3");
        req(16'hC000, "R6 back-to-back a");
        req(16'hC001, "R6 back-to-back b");

        // Mixed random traffic
        for (int n = 0; n < 400; n++) begin
            step(1'($urandom), int'($urandom & 3), 1'($urandom), int'($urandom),
                 int'($urandom), 1'($urandom), int'($urandom & 16'hFFFF),
                 "R2 R3 R4 R6 R8 random");
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule